// File: doc/BRIEF.md
# ECC Error Capture and Reporting Unit

This unit sits next to a 64-bit memory datapath protected by eight check bits and turns per-access error pulses into software-visible state. The ECC logic reports three kinds of event: correctable single-bit errors, uncorrectable multi-bit errors and one non-ECC error. Each event pulse comes with the data word, the check bits and the address of the access that failed. The unit keeps sticky flags for these events and counts single-bit errors against a programmable limit. It also captures the first failing access and drives one level interrupt.

The same register space holds masks for fault injection. When injection is enabled, the masks are XORed into the data and check bits on their way to the memory. Software can then plant known errors and see them come back as events.

All registers are 32 bits wide and sit on a simple bus with a word index. Reads are combinational. A write takes effect on the clock edge where the bus select and write strobe are high.

Top module: `ecc_err_report`

## Requirements
- R1: After reset every register reads 0 and `irq` is low. Indexes 12 to 15 always read 0.
- R2: An enabled multi-bit event sets status bit 1. The bit stays set until software clears it.
- R3: An enabled non-ECC event sets status bit 2. It never loads the capture registers.
- R4: A write to status (index 0) clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. Writing 0xFFFFFFFF clears all flags. If an event arrives in the same cycle as the clearing write, the event wins.
- R5: Disable register (index 1) bits 0, 1 and 2 block single-bit, multi-bit and non-ECC events. A blocked single-bit event does not advance the counter. Writing 0 enables all detection.
- R6: Threshold control (index 3) holds the limit in bits 23:16 and shows the running count in bits 7:0, which are read-only. The single-bit event that brings the count up to a non-zero limit sets status bit 0, and the count returns to 0. With a limit of 0 the count keeps running and the flag is never set. Any write to index 3 resets the count.
- R7: `irq` is high exactly when some status flag is set and its matching bit in the interrupt enable register (index 2, same bit positions) is set.
- R8: Capture loads on an enabled single-bit or multi-bit event while status bits 0 and 1 are both clear. Data bits 63:32 go to index 4, bits 31:0 to index 5, check bits to index 6, address bits 31:0 to index 7 and address bits 39:32 to index 8. The capture holds while bit 0 or bit 1 is set.
- R9: Inject masks sit at index 9 (data bits 63:32), index 10 (data bits 31:0) and index 11 (bits 7:0 check mask, bit 8 enable). All three read back what was written. With bit 8 set, the outputs are the inputs XOR the masks. With bit 8 clear, the outputs equal the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, taken when bus_sel is high |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ev_sbe | input | 1 | Single-bit error pulse |
| ev_mbe | input | 1 | Multi-bit error pulse |
| ev_other | input | 1 | Non-ECC error pulse |
| ev_data | input | 64 | Data word of the failing access |
| ev_check | input | 8 | Check bits of the failing access |
| ev_addr | input | 40 | Address of the failing access |
| wr_data_in | input | 64 | Write data toward memory |
| wr_check_in | input | 8 | Check bits toward memory |
| wr_data_out | output | 64 | Write data after injection |
| wr_check_out | output | 8 | Check bits after injection |
| irq | output | 1 | Level interrupt |

## Verification
The error paths are driven with isolated multi-bit pulses, a second multi-bit pulse while the flag is still set, and runs of single-bit pulses under a limit of 3 and a limit of 0. These separate first-error capture from overwrite, and separate a threshold trip from plain counting.

Clearing writes use partial bit patterns, the all-ones pattern, and a clear in the same cycle as a new event. These patterns show that clearing is selective and that an arriving event has priority.

Disabled events and a non-ECC event check that masking stops both the flags and the counter. They also check that the non-ECC path leaves the captured access untouched.

Injection is tried with the enable bit off and on, using the same masks, so a bypass and an applied XOR give different outputs.

// File: rtl/ecc_rpt_pkg.sv
package ecc_rpt_pkg;
    localparam int REG_AW     = 4;
    localparam int BUS_W      = 32;
    localparam int FLAG_N     = 3;
    localparam int FLAG_SBE   = 0;
    localparam int FLAG_MBE   = 1;
    localparam int FLAG_OTHER = 2;
    localparam int THR_LSB    = 16;
    localparam int INJ_EN_BIT = 8;

    typedef enum logic [REG_AW-1:0] {
        RA_STATUS  = 4'd0,
        RA_DISABLE = 4'd1,
        RA_IRQEN   = 4'd2,
        RA_SBECTL  = 4'd3,
        RA_CAPHI   = 4'd4,
        RA_CAPLO   = 4'd5,
        RA_CAPCHK  = 4'd6,
        RA_ADDRLO  = 4'd7,
        RA_ADDRHI  = 4'd8,
        RA_INJHI   = 4'd9,
        RA_INJLO   = 4'd10,
        RA_INJCTL  = 4'd11
    } reg_addr_e;
endpackage

// File: rtl/ecc_rpt_sbe_count.sv
module ecc_rpt_sbe_count #(
    parameter int THR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             thr_wr,
    input  logic [THR_W-1:0] thr_wdata,
    input  logic             sbe_hit,
    output logic [THR_W-1:0] thr_o,
    output logic [THR_W-1:0] cnt_o,
    output logic             trip_o
);
    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic [THR_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [THR_W-1:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + THR_W'(1);
        trip_o  = 1'b0;
        if (thr_wr) begin
            // a write to the control register has priority and restarts the count
            st_d.thr = thr_wdata;
            st_d.cnt = '0;
        end else if (sbe_hit) begin
            if ((st_q.thr != '0) && (cnt_inc == st_q.thr)) begin
                trip_o   = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign thr_o = st_q.thr;
    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/ecc_rpt_capture.sv
module ecc_rpt_capture #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] data_o,
    output logic [CHK_W-1:0]  chk_o,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  chk;
        logic [ADDR_W-1:0] addr;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.data = data_i;
            st_d.chk  = chk_i;
            st_d.addr = addr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign chk_o  = st_q.chk;
    assign addr_o = st_q.addr;
endmodule

// File: rtl/ecc_rpt_inject.sv
module ecc_rpt_inject
    import ecc_rpt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic              wr_ctl,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [DATA_W-1:0] path_data_i,
    input  logic [CHK_W-1:0]  path_chk_i,
    output logic [DATA_W-1:0] path_data_o,
    output logic [CHK_W-1:0]  path_chk_o,
    output logic [BUS_W-1:0]  hi_word_o,
    output logic [BUS_W-1:0]  lo_word_o,
    output logic [BUS_W-1:0]  ctl_word_o,
    output logic              en_o
);
    localparam int HALF = DATA_W / 2;

    typedef struct packed {
        logic [HALF-1:0]  mhi;
        logic [HALF-1:0]  mlo;
        logic [CHK_W-1:0] mchk;
        logic             en;
    } inj_state_t;

    inj_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hi)  st_d.mhi  = wdata[HALF-1:0];
        if (wr_lo)  st_d.mlo  = wdata[HALF-1:0];
        if (wr_ctl) begin
            st_d.mchk = wdata[CHK_W-1:0];
            st_d.en   = wdata[INJ_EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        ctl_word_o                = '0;
        ctl_word_o[CHK_W-1:0]     = st_q.mchk;
        ctl_word_o[INJ_EN_BIT]    = st_q.en;
        hi_word_o                 = BUS_W'(st_q.mhi);
        lo_word_o                 = BUS_W'(st_q.mlo);
        path_data_o = st_q.en ? (path_data_i ^ {st_q.mhi, st_q.mlo}) : path_data_i;
        path_chk_o  = st_q.en ? (path_chk_i ^ st_q.mchk) : path_chk_i;
    end

    assign en_o = st_q.en;
endmodule

// File: rtl/ecc_err_report.sv
module ecc_err_report
    import ecc_rpt_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 40,
    parameter int THR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ev_sbe,
    input  logic              ev_mbe,
    input  logic              ev_other,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [CHK_W-1:0]  ev_check,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic [DATA_W-1:0] wr_data_in,
    input  logic [CHK_W-1:0]  wr_check_in,
    output logic [DATA_W-1:0] wr_data_out,
    output logic [CHK_W-1:0]  wr_check_out,
    output logic              irq
);
    localparam int HALF      = DATA_W / 2;
    localparam int ADDR_HI_W = ADDR_W - BUS_W;

    typedef struct packed {
        logic [FLAG_N-1:0] flags;
        logic [FLAG_N-1:0] dis;
        logic [FLAG_N-1:0] ien;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic              wr_stb;
    logic              hit_sbe, hit_mbe, hit_oth;
    logic              sbe_trip;
    logic              cap_load;
    logic [FLAG_N-1:0] clr_mask, set_mask;
    logic [THR_W-1:0]  thr_q, cnt_q;
    logic [DATA_W-1:0] cap_data;
    logic [CHK_W-1:0]  cap_chk;
    logic [ADDR_W-1:0] cap_addr;
    logic [BUS_W-1:0]  inj_hi_w, inj_lo_w, inj_ctl_w;
    logic              inj_en;
    logic [FLAG_N-1:0] flags_q, dis_q, ien_q;

    assign wr_stb  = bus_sel && bus_wr;
    assign hit_sbe = ev_sbe   && !st_q.dis[FLAG_SBE];
    assign hit_mbe = ev_mbe   && !st_q.dis[FLAG_MBE];
    assign hit_oth = ev_other && !st_q.dis[FLAG_OTHER];

    ecc_rpt_sbe_count #(.THR_W(THR_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .thr_wr    (wr_stb && (bus_addr == RA_SBECTL)),
        .thr_wdata (bus_wdata[THR_LSB +: THR_W]),
        .sbe_hit   (hit_sbe),
        .thr_o     (thr_q),
        .cnt_o     (cnt_q),
        .trip_o    (sbe_trip)
    );

    // first ECC error wins: capture only while both ECC flags are clear
    assign cap_load = (hit_sbe || hit_mbe) && !st_q.flags[FLAG_SBE] && !st_q.flags[FLAG_MBE];

    ecc_rpt_capture #(.DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W)) u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cap_load),
        .data_i (ev_data),
        .chk_i  (ev_check),
        .addr_i (ev_addr),
        .data_o (cap_data),
        .chk_o  (cap_chk),
        .addr_o (cap_addr)
    );

    ecc_rpt_inject #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_inj (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hi       (wr_stb && (bus_addr == RA_INJHI)),
        .wr_lo       (wr_stb && (bus_addr == RA_INJLO)),
        .wr_ctl      (wr_stb && (bus_addr == RA_INJCTL)),
        .wdata       (bus_wdata),
        .path_data_i (wr_data_in),
        .path_chk_i  (wr_check_in),
        .path_data_o (wr_data_out),
        .path_chk_o  (wr_check_out),
        .hi_word_o   (inj_hi_w),
        .lo_word_o   (inj_lo_w),
        .ctl_word_o  (inj_ctl_w),
        .en_o        (inj_en)
    );

    always_comb begin
        st_d     = st_q;
        clr_mask = '0;
        set_mask = '0;
        set_mask[FLAG_SBE]   = sbe_trip;
        set_mask[FLAG_MBE]   = hit_mbe;
        set_mask[FLAG_OTHER] = hit_oth;
        if (wr_stb) begin
            case (bus_addr)
                RA_STATUS:  clr_mask = bus_wdata[FLAG_N-1:0];
                RA_DISABLE: st_d.dis = bus_wdata[FLAG_N-1:0];
                RA_IRQEN:   st_d.ien = bus_wdata[FLAG_N-1:0];
                default:    ;
            endcase
        end
        // a new event in the clearing cycle survives the clear
        st_d.flags = (st_q.flags & ~clr_mask) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_STATUS:  bus_rdata = BUS_W'(st_q.flags);
            RA_DISABLE: bus_rdata = BUS_W'(st_q.dis);
            RA_IRQEN:   bus_rdata = BUS_W'(st_q.ien);
            RA_SBECTL: begin
                bus_rdata[THR_LSB +: THR_W] = thr_q;
                bus_rdata[THR_W-1:0]        = cnt_q;
            end
            RA_CAPHI:   bus_rdata = cap_data[DATA_W-1:HALF];
            RA_CAPLO:   bus_rdata = cap_data[HALF-1:0];
            RA_CAPCHK:  bus_rdata = BUS_W'(cap_chk);
            RA_ADDRLO:  bus_rdata = cap_addr[BUS_W-1:0];
            RA_ADDRHI:  bus_rdata = BUS_W'(cap_addr[ADDR_W-1:BUS_W]);
            RA_INJHI:   bus_rdata = inj_hi_w;
            RA_INJLO:   bus_rdata = inj_lo_w;
            RA_INJCTL:  bus_rdata = inj_ctl_w;
            default:    bus_rdata = '0;
        endcase
    end

    assign irq     = |(st_q.flags & st_q.ien);
    assign flags_q = st_q.flags;
    assign dis_q   = st_q.dis;
    assign ien_q   = st_q.ien;
endmodule

// File: rtl/ecc_rpt_chk.sv
module ecc_rpt_chk #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 40,
    parameter int THR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              ev_mbe,
    input logic              ev_other,
    input logic [2:0]        flags,
    input logic [2:0]        dis,
    input logic              irq,
    input logic [THR_W-1:0]  thr,
    input logic [THR_W-1:0]  cnt,
    input logic [DATA_W-1:0] cap_data,
    input logic [CHK_W-1:0]  cap_chk,
    input logic [ADDR_W-1:0] cap_addr,
    input logic              inj_en,
    input logic [DATA_W-1:0] wr_data_in,
    input logic [DATA_W-1:0] wr_data_out,
    input logic [CHK_W-1:0]  wr_check_in,
    input logic [CHK_W-1:0]  wr_check_out
);
    AST_MBE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mbe && !dis[1]) |=> flags[1]); // R2
    AST_OTHER_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_other && !dis[2]) |=> flags[2]); // R3
    AST_W1C_CLEARS_MBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 4'd0 && bus_wdata[1] && !ev_mbe) |=> !flags[1]); // R4
    AST_DISABLED_MBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[1] && ev_mbe && dis[1]) |=> !flags[1]); // R5
    AST_COUNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (thr != '0) |-> (cnt < thr)); // R6
    AST_NO_FLAG_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 3'b000) |-> !irq); // R7
    AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] || flags[1]) |=> ($stable(cap_data) && $stable(cap_chk) && $stable(cap_addr))); // R8
    AST_INJECT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_en |-> (wr_data_out == wr_data_in && wr_check_out == wr_check_in)); // R9
endmodule

bind ecc_err_report ecc_rpt_chk #(
    .DATA_W(DATA_W), .CHK_W(CHK_W), .ADDR_W(ADDR_W), .THR_W(THR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .ev_mbe       (ev_mbe),
    .ev_other     (ev_other),
    .flags        (flags_q),
    .dis          (dis_q),
    .irq          (irq),
    .thr          (thr_q),
    .cnt          (cnt_q),
    .cap_data     (cap_data),
    .cap_chk      (cap_chk),
    .cap_addr     (cap_addr),
    .inj_en       (inj_en),
    .wr_data_in   (wr_data_in),
    .wr_data_out  (wr_data_out),
    .wr_check_in  (wr_check_in),
    .wr_check_out (wr_check_out)
);

// File: tb/ecc_err_report_test.sv
module ecc_err_report_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_sbe = 1'b0, ev_mbe = 1'b0, ev_other = 1'b0;
    logic [63:0] ev_data = '0;
    logic [7:0]  ev_check = '0;
    logic [39:0] ev_addr = '0;
    logic [63:0] wr_data_in = '0;
    logic [7:0]  wr_check_in = '0;
    logic [63:0] wr_data_out;
    logic [7:0]  wr_check_out;
    logic        irq;

    int unsigned n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_err_report uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_sbe(ev_sbe), .ev_mbe(ev_mbe), .ev_other(ev_other),
        .ev_data(ev_data), .ev_check(ev_check), .ev_addr(ev_addr),
        .wr_data_in(wr_data_in), .wr_check_in(wr_check_in),
        .wr_data_out(wr_data_out), .wr_check_out(wr_check_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic s, input logic m, input logic o,
                         input logic [63:0] d, input logic [7:0] c, input logic [39:0] a);
        @(negedge clk);
        ev_sbe = s; ev_mbe = m; ev_other = o; ev_data = d; ev_check = c; ev_addr = a;
        @(negedge clk);
        ev_sbe = 1'b0; ev_mbe = 1'b0; ev_other = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(4'(i), v);
            check($sformatf("R1 reg %0d after reset", i), 64'(v), 64'h0);
        end
        check("R1 irq after reset", 64'(irq), 64'h0);
    endtask

    task automatic t_inject();
        logic [31:0] v;
        wr_data_in  = 64'h0123_4567_89AB_CDEF;
        wr_check_in = 8'h3C;
        wr(4'd9, 32'h8000_0001);
        wr(4'd10, 32'h0000_0100);
        wr(4'd11, 32'h0000_00A5);
        #1;
        check("R9 bypass data", wr_data_out, 64'h0123_4567_89AB_CDEF);
        check("R9 bypass check", 64'(wr_check_out), 64'h3C);
        wr(4'd11, 32'h0000_01A5);
        #1;
        check("R9 inject data", wr_data_out, 64'h0123_4567_89AB_CDEF ^ 64'h8000_0001_0000_0100);
        check("R9 inject check", 64'(wr_check_out), 64'(8'h3C ^ 8'hA5));
        rd(4'd9, v);  check("R9 readback hi", 64'(v), 64'h8000_0001);
        rd(4'd10, v); check("R9 readback lo", 64'(v), 64'h0000_0100);
        rd(4'd11, v); check("R9 readback ctl", 64'(v), 64'h1A5);
        wr(4'd11, 32'h0);
    endtask

    task automatic t_mbe();
        logic [31:0] v;
        wr(4'd2, 32'h2);
        pulse(1'b0, 1'b1, 1'b0, 64'hDEAD_BEEF_CAFE_F00D, 8'h5A, 40'hAB_1234_5678);
        rd(4'd0, v); check("R2 mbe flag", 64'(v), 64'h2);
        check("R7 irq with mbe enabled", 64'(irq), 64'h1);
        rd(4'd4, v); check("R8 cap hi", 64'(v), 64'hDEAD_BEEF);
        rd(4'd5, v); check("R8 cap lo", 64'(v), 64'hCAFE_F00D);
        rd(4'd6, v); check("R8 cap check", 64'(v), 64'h5A);
        rd(4'd7, v); check("R8 addr lo", 64'(v), 64'h1234_5678);
        rd(4'd8, v); check("R8 addr hi", 64'(v), 64'hAB);
        pulse(1'b0, 1'b1, 1'b0, 64'h1111_2222_3333_4444, 8'h01, 40'h00_0000_0040);
        rd(4'd5, v); check("R8 first error kept", 64'(v), 64'hCAFE_F00D);
        wr(4'd0, 32'h1);
        rd(4'd0, v); check("R4 zero bit leaves flag", 64'(v), 64'h2);
        wr(4'd0, 32'h2);
        rd(4'd0, v); check("R4 one bit clears flag", 64'(v), 64'h0);
        check("R7 irq drops on clear", 64'(irq), 64'h0);
        wr(4'd2, 32'h0);
        pulse(1'b0, 1'b1, 1'b0, 64'h0, 8'h0, 40'h0);
        rd(4'd0, v); check("R2 flag set with irq off", 64'(v), 64'h2);
        check("R7 irq stays low when disabled", 64'(irq), 64'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); check("R4 all ones clears", 64'(v), 64'h0);
    endtask

    task automatic t_sbe();
        logic [31:0] v;
        wr(4'd2, 32'h1);
        wr(4'd3, 32'h0003_0000);
        pulse(1'b1, 1'b0, 1'b0, 64'hA, 8'h1, 40'h10);
        pulse(1'b1, 1'b0, 1'b0, 64'hB, 8'h2, 40'h20);
        rd(4'd0, v); check("R6 below limit no flag", 64'(v), 64'h0);
        rd(4'd3, v); check("R6 count two", 64'(v), 64'h0003_0002);
        check("R7 irq low below limit", 64'(irq), 64'h0);
        pulse(1'b1, 1'b0, 1'b0, 64'h0000_0007_0000_000C, 8'h3, 40'h30);
        rd(4'd0, v); check("R6 limit sets flag", 64'(v), 64'h1);
        rd(4'd3, v); check("R6 count back to zero", 64'(v), 64'h0003_0000);
        check("R7 irq on sbe flag", 64'(irq), 64'h1);
        rd(4'd5, v); check("R8 capture of tripping sbe", 64'(v), 64'hC);
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd3, 32'h0);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0, 1'b0, 64'h0, 8'h0, 40'h0);
        rd(4'd0, v); check("R6 zero limit never flags", 64'(v), 64'h0);
        rd(4'd3, v); check("R6 zero limit keeps counting", 64'(v), 64'h3);
        wr(4'd3, 32'h0001_0000);
        rd(4'd3, v); check("R6 write resets count", 64'(v), 64'h0001_0000);
        wr(4'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        wr(4'd1, 32'h7);
        pulse(1'b1, 1'b1, 1'b1, 64'h9999, 8'h9, 40'h99);
        rd(4'd0, v); check("R5 disabled events ignored", 64'(v), 64'h0);
        rd(4'd3, v); check("R5 disabled sbe not counted", 64'(v), 64'h0001_0000);
        rd(4'd5, v); check("R5 disabled no capture", 64'(v), 64'h0);
        wr(4'd1, 32'h0);
        pulse(1'b0, 1'b0, 1'b1, 64'h7777, 8'h7, 40'h77);
        rd(4'd0, v); check("R3 other flag", 64'(v), 64'h4);
        rd(4'd5, v); check("R3 other leaves capture", 64'(v), 64'h0);
        wr(4'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_race();
        logic [31:0] v;
        pulse(1'b0, 1'b1, 1'b0, 64'h0, 8'h0, 40'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h2; ev_mbe = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev_mbe = 1'b0;
        rd(4'd0, v); check("R4 event wins over clear", 64'(v), 64'h2);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); check("R4 final clear", 64'(v), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_inject();
        t_mbe();
        t_sbe();
        t_disable();
        t_race();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule